// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter driven by a slow tick strobe that is sampled on the system clock. Each tick advances a prescaler that divides by 32 or by 128. Every prescaler wrap advances a postscaler whose terminal count is a power of two chosen by a 4-bit code. When both stages reach their terminal values on the same tick, the watchdog has expired. In run mode an expiry raises a one-cycle reset request. In idle or sleep it raises a one-cycle wake request instead, so that the processor continues from the point where it entered low power. Every expiry also sets a sticky flag, and only software can clear it.

Several events restart the count: a software clear, completion of a clock switch, entry into low power and exit from low power. An optional window mode accepts a software clear only in the last quarter of the period. An earlier clear counts as a violation and is handled like an expiry. A 2-bit enable mode selects one of four behaviours: always on, on except in sleep, or gated by a software enable bit (two codes). The configuration inputs are captured only while reset is held.

Top module: `wwdt_top`

## Requirements
- R1: `cfg_long_pre` low makes the prescaler divide ticks by 32, and high makes it divide by 128. An expiry happens after exactly prescale × 2^code ticks counted from a restart.
- R2: `cfg_post_code` n (0 to 15) sets the postscaler ratio to 2^n prescaler wraps.
- R3: A pulse on `clk_switch_done`, `lp_enter` or `lp_exit`, or an accepted clear, sets both counts to zero. In that cycle the tick is ignored and any expiry is cancelled, including a terminal tick that arrives in the same cycle.
- R4: With `cfg_window` high, a clear whose elapsed tick count is below three quarters of the period is a violation. A clear at or above that point is accepted. With `cfg_window` low, every clear is accepted.
- R5: Enable mode 2'b11 is always on. Mode 2'b01 is on unless `pwr_mode` is sleep, and ignores the software bit. Modes 2'b10 and 2'b00 follow the software bit. While the block is off, both counts stay at zero and no request is raised.
- R6: The software enable bit takes `sw_en_val` whenever `sw_en_wr` is pulsed, and reset clears it.
- R7: An expiry or violation while `pwr_mode` is run (2'b00) drives `rst_req` high for the single cycle after the edge at which it occurs. The counts restart from zero at that edge.
- R8: An expiry or violation while `pwr_mode` is idle (2'b01), sleep (2'b10) or 2'b11 drives `wake_req` for one cycle in place of `rst_req`.
- R9: `timeout_flag` is set by every expiry or violation. It stays set until `flag_clr` is pulsed, and a set in the same cycle as a clear takes priority. Reset clears the flag.
- R10: The configuration inputs are captured on clock edges only while `rst_n` is low. A change after reset is released has no effect.
- R11: While reset is held, `rst_req`, `wake_req` and `timeout_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low device reset |
| tick | input | 1 | Slow tick strobe, one count per high clock cycle |
| cfg_long_pre | input | 1 | Prescale select: 0 gives /32, 1 gives /128 |
| cfg_post_code | input | 4 | Postscale code n, ratio 2^n |
| cfg_en_mode | input | 2 | Enable mode |
| cfg_window | input | 1 | Window mode on |
| sw_en_wr | input | 1 | Write strobe for the software enable bit |
| sw_en_val | input | 1 | Value written to the software enable bit |
| sw_clear | input | 1 | Software clear strobe |
| pwr_mode | input | 2 | 00 run, 01 idle, 10 sleep, 11 treated as low power |
| clk_switch_done | input | 1 | Clock switch completed strobe |
| lp_enter | input | 1 | Low-power entry strobe |
| lp_exit | input | 1 | Low-power exit strobe |
| flag_clr | input | 1 | Clears the timeout flag |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake request |
| timeout_flag | output | 1 | Sticky watchdog event flag |

## Verification
An accepted software clear can arrive in the same cycle as the tick that would complete the period. The bench provokes this by counting ticks from reset to one short of the period and then pulsing the clear together with the final tick, with window mode both on and off. The bench expects no request in that cycle, followed by a full fresh period before the next expiry. A flag clear that lands on the expiry edge is also exercised, and there the flag must stay set.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_IDLE  = 2'b01,
    PM_SLEEP = 2'b10,
    PM_LOW3  = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    EN_SOFT0   = 2'b00,
    EN_NOSLEEP = 2'b01,
    EN_SOFT    = 2'b10,
    EN_ALWAYS  = 2'b11
  } en_mode_e;
endpackage

// File: rtl/wwdt_prescaler.sv
module wwdt_prescaler #(
  parameter int SHORT_LOG = 5,
  parameter int LONG_LOG  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                step,
  input  logic                long_sel,
  output logic [LONG_LOG-1:0] cnt,
  output logic                carry
);
  localparam logic [LONG_LOG-1:0] SHORT_LAST = LONG_LOG'((1 << SHORT_LOG) - 1);
  localparam logic [LONG_LOG-1:0] LONG_LAST  = LONG_LOG'((1 << LONG_LOG) - 1);

  logic [LONG_LOG-1:0] last_val;

  assign last_val = long_sel ? LONG_LAST : SHORT_LAST;
  assign carry    = step && !restart && (cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= carry ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wwdt_postscaler.sv
module wwdt_postscaler #(
  parameter int CODE_W = 4,
  localparam int POST_W = (1 << CODE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic [POST_W-1:0] cnt,
  output logic              expire
);
  logic [POST_W:0]   weight;
  logic [POST_W-1:0] last_val;

  assign weight   = (POST_W+1)'(1) << code;
  assign last_val = POST_W'(weight - 1'b1);
  assign expire   = step && !restart && (cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (step)    cnt <= expire ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wwdt_enable_gate.sv
module wwdt_enable_gate
  import wwdt_pkg::*;
(
  input  logic [1:0] mode,
  input  logic [1:0] pwr,
  input  logic       sw_bit,
  output logic       active
);
  always_comb begin
    unique case (en_mode_e'(mode))
      EN_ALWAYS:  active = 1'b1;
      EN_NOSLEEP: active = (pwr_mode_e'(pwr) != PM_SLEEP);
      default:    active = sw_bit;
    endcase
  end
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int SHORT_LOG = 5,
  parameter int LONG_LOG  = 7,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_long_pre,
  input  logic [CODE_W-1:0] cfg_post_code,
  input  logic [1:0]        cfg_en_mode,
  input  logic              cfg_window,
  input  logic              sw_en_wr,
  input  logic              sw_en_val,
  input  logic              sw_clear,
  input  logic [1:0]        pwr_mode,
  input  logic              clk_switch_done,
  input  logic              lp_enter,
  input  logic              lp_exit,
  input  logic              flag_clr,
  output logic              rst_req,
  output logic              wake_req,
  output logic              timeout_flag
);
  localparam int POST_W = (1 << CODE_W) - 1;
  localparam int EW     = LONG_LOG + POST_W;
  localparam int SHW    = $clog2(EW + 1) + 1;

  // configuration captured during reset only
  logic              long_q;
  logic [CODE_W-1:0] code_q;
  logic [1:0]        en_mode_q;
  logic              window_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      long_q    <= cfg_long_pre;
      code_q    <= cfg_post_code;
      en_mode_q <= cfg_en_mode;
      window_q  <= cfg_window;
    end
  end

  logic sw_bit;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sw_bit <= 1'b0;
    else if (sw_en_wr) sw_bit <= sw_en_val;
  end

  logic active;
  wwdt_enable_gate u_gate (
    .mode   (en_mode_q),
    .pwr    (pwr_mode),
    .sw_bit (sw_bit),
    .active (active)
  );

  logic [LONG_LOG-1:0] pre_cnt;
  logic [POST_W-1:0]   post_cnt;
  logic                pre_carry;
  logic                expire;
  logic                restart;

  wwdt_prescaler #(.SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .step     (tick && active),
    .long_sel (long_q),
    .cnt      (pre_cnt),
    .carry    (pre_carry)
  );

  wwdt_postscaler #(.CODE_W(CODE_W)) u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (pre_carry),
    .code    (code_q),
    .cnt     (post_cnt),
    .expire  (expire)
  );

  // elapsed ticks as one number, period and window threshold
  logic [EW-1:0]  elapsed;
  logic [SHW-1:0] shamt;
  logic [EW:0]    period;
  logic [EW:0]    threshold;
  logic           in_window;

  always_comb begin
    if (long_q) elapsed = {post_cnt, pre_cnt};
    else        elapsed = EW'({post_cnt, pre_cnt[SHORT_LOG-1:0]});
  end

  assign shamt     = SHW'(long_q ? LONG_LOG : SHORT_LOG) + SHW'(code_q);
  assign period    = (EW+1)'(1) << shamt;
  assign threshold = period - (period >> 2);
  assign in_window = {1'b0, elapsed} >= threshold;

  logic clr_ok, clr_bad, fire, low_power;

  assign clr_ok    = sw_clear && active && (!window_q || in_window);
  assign clr_bad   = sw_clear && active && window_q && !in_window;
  assign restart   = !active || clk_switch_done || lp_enter || lp_exit || clr_ok || clr_bad;
  assign fire      = expire || clr_bad;
  assign low_power = (pwr_mode_e'(pwr_mode) != PM_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req      <= 1'b0;
      wake_req     <= 1'b0;
      timeout_flag <= 1'b0;
    end else begin
      rst_req  <= fire && !low_power;
      wake_req <= fire && low_power;
      if (fire)          timeout_flag <= 1'b1;
      else if (flag_clr) timeout_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker #(
  parameter int LONG_LOG = 7,
  parameter int POST_W   = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          pwr_mode,
  input logic [1:0]          en_mode_q,
  input logic                active,
  input logic [LONG_LOG-1:0] pre_cnt,
  input logic [POST_W-1:0]   post_cnt,
  input logic                flag_clr,
  input logic                rst_req,
  input logic                wake_req,
  input logic                timeout_flag
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req)); // R8

  AST_RST_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(pwr_mode) == 2'b00)); // R7

  AST_WAKE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($past(pwr_mode) != 2'b00)); // R8

  AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || wake_req) |-> timeout_flag); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !flag_clr) |=> timeout_flag); // R9

  AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mode_q == 2'b01 && pwr_mode == 2'b10) |=> !(rst_req || wake_req)); // R5

  AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (pre_cnt == '0 && post_cnt == '0)); // R5
endmodule

bind wwdt_top wwdt_checker #(.LONG_LOG(LONG_LOG), .POST_W(POST_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_mode     (pwr_mode),
  .en_mode_q    (en_mode_q),
  .active       (active),
  .pre_cnt      (pre_cnt),
  .post_cnt     (post_cnt),
  .flag_clr     (flag_clr),
  .rst_req      (rst_req),
  .wake_req     (wake_req),
  .timeout_flag (timeout_flag)
);

// File: tb/test_wwdt_top.sv
module test_wwdt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_long_pre = 1'b0;
  logic [3:0] cfg_post_code = '0;
  logic [1:0] cfg_en_mode = 2'b11;
  logic       cfg_window = 1'b0;
  logic       sw_en_wr = 1'b0;
  logic       sw_en_val = 1'b0;
  logic       sw_clear = 1'b0;
  logic [1:0] pwr_mode = 2'b00;
  logic       clk_switch_done = 1'b0;
  logic       lp_enter = 1'b0;
  logic       lp_exit = 1'b0;
  logic       flag_clr = 1'b0;
  logic       rst_req, wake_req, timeout_flag;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ev_n;
  bit ev_rst, ev_wake;

  always #4 clk = ~clk;

  wwdt_top i_wwdt_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_long_pre(cfg_long_pre),
    .cfg_post_code(cfg_post_code), .cfg_en_mode(cfg_en_mode), .cfg_window(cfg_window),
    .sw_en_wr(sw_en_wr), .sw_en_val(sw_en_val), .sw_clear(sw_clear), .pwr_mode(pwr_mode),
    .clk_switch_done(clk_switch_done), .lp_enter(lp_enter), .lp_exit(lp_exit),
    .flag_clr(flag_clr), .rst_req(rst_req), .wake_req(wake_req), .timeout_flag(timeout_flag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset(input bit lng, input int code, input int mode, input bit win, input int pm);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; sw_clear = 0; sw_en_wr = 0; flag_clr = 0;
    clk_switch_done = 0; lp_enter = 0; lp_exit = 0;
    cfg_long_pre = lng; cfg_post_code = 4'(code); cfg_en_mode = 2'(mode);
    cfg_window = win; pwr_mode = 2'(pm);
    repeat (3) @(negedge clk);
    check(!rst_req && !wake_req && !timeout_flag, "R11", "outputs in reset",
          int'({rst_req, wake_req, timeout_flag}), 0);
    rst_n = 1'b1;
    tick = 1'b1;
  endtask

  task automatic count_event(input int max_n);
    ev_n = 0; ev_rst = 0; ev_wake = 0;
    for (int i = 0; i < max_n; i++) begin
      @(negedge clk);
      ev_n++;
      if (rst_req || wake_req) begin
        ev_rst = rst_req; ev_wake = wake_req;
        break;
      end
    end
  endtask

  task automatic expect_event(input int exp_n, input bit want_rst, input string req);
    count_event(exp_n + 40);
    check(ev_n == exp_n, req, "cycles to event", ev_n, exp_n);
    check(want_rst ? (ev_rst && !ev_wake) : (ev_wake && !ev_rst), req, "request kind",
          int'({ev_rst, ev_wake}), want_rst ? 2 : 1);
  endtask

  task automatic expect_quiet(input int n, input string req);
    count_event(n);
    check(!ev_rst && !ev_wake, req, "no request", int'({ev_rst, ev_wake}), 0);
  endtask

  task automatic pulse_clear();
    sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
  endtask

  // R1 R7 R9 R11: basic expiry with /32 and code 0
  task automatic t_basic();
    apply_reset(0, 0, 3, 0, 0);
    expect_event(32, 1, "R1");
    check(timeout_flag, "R9", "flag set", timeout_flag, 1);
    @(negedge clk);
    check(!rst_req, "R7", "reset request one cycle", rst_req, 0);
    expect_event(31, 1, "R7");
  endtask

  // R1 R2: prescale and postscale ratios
  task automatic t_ratios();
    apply_reset(0, 3, 3, 0, 0);
    expect_event(256, 1, "R2");
    apply_reset(1, 2, 3, 0, 0);
    expect_event(512, 1, "R1");
  endtask

  // R10: configuration change after reset ignored
  task automatic t_cfg_frozen();
    apply_reset(0, 0, 3, 0, 0);
    expect_quiet(10, "R10");
    cfg_post_code = 4'd4; cfg_long_pre = 1'b1; cfg_en_mode = 2'b00;
    expect_event(22, 1, "R10");
  endtask

  // R4: window boundaries (period 128, threshold 96)
  task automatic t_window();
    apply_reset(0, 2, 3, 1, 0);
    expect_quiet(95, "R4");
    pulse_clear();
    check(rst_req, "R4", "early clear violation at 95", rst_req, 1);
    expect_quiet(96, "R4");
    pulse_clear();
    check(!rst_req, "R4", "clear accepted at 96", rst_req, 0);
    expect_event(128, 1, "R4");
    apply_reset(0, 2, 3, 0, 0);
    expect_quiet(10, "R4");
    pulse_clear();
    check(!rst_req, "R4", "clear accepted without window", rst_req, 0);
    expect_event(128, 1, "R4");
  endtask

  // R3: clear coinciding with terminal tick, window off and on
  task automatic t_coincide();
    for (int w = 0; w < 2; w++) begin
      apply_reset(0, 0, 3, w[0], 0);
      expect_quiet(31, "R3");
      pulse_clear();
      check(!rst_req && !wake_req, "R3", "clear beats terminal tick", rst_req, 0);
      expect_event(32, 1, "R3");
    end
  endtask

  // R3 R8: other restart events and wake in low power
  task automatic t_events();
    apply_reset(0, 0, 3, 0, 0);
    expect_quiet(20, "R3");
    clk_switch_done = 1'b1; @(negedge clk); clk_switch_done = 1'b0;
    expect_event(32, 1, "R3");
    expect_quiet(10, "R3");
    pwr_mode = 2'b01; lp_enter = 1'b1; @(negedge clk); lp_enter = 1'b0;
    expect_event(32, 0, "R8");
    expect_quiet(5, "R3");
    pwr_mode = 2'b00; lp_exit = 1'b1; @(negedge clk); lp_exit = 1'b0;
    expect_event(32, 1, "R3");
    apply_reset(0, 0, 3, 0, 2);
    expect_event(32, 0, "R8");
    check(timeout_flag, "R9", "flag after wake", timeout_flag, 1);
  endtask

  // R5 R6: enable modes and software bit
  task automatic t_enable();
    apply_reset(0, 0, 1, 0, 2);
    sw_en_val = 1'b1; sw_en_wr = 1'b1; @(negedge clk); sw_en_wr = 1'b0;
    expect_quiet(80, "R5");
    pwr_mode = 2'b00;
    expect_event(32, 1, "R5");
    apply_reset(0, 0, 2, 0, 0);
    expect_quiet(80, "R5");
    sw_en_val = 1'b1; sw_en_wr = 1'b1; @(negedge clk); sw_en_wr = 1'b0;
    expect_event(32, 1, "R6");
    apply_reset(0, 0, 2, 0, 0);
    expect_quiet(80, "R6");
    apply_reset(0, 0, 0, 0, 0);
    expect_quiet(40, "R5");
    sw_en_val = 1'b1; sw_en_wr = 1'b1; @(negedge clk); sw_en_wr = 1'b0;
    expect_event(32, 1, "R5");
  endtask

  // R9: sticky flag, clear, set wins
  task automatic t_flag();
    apply_reset(0, 0, 3, 0, 0);
    expect_event(32, 1, "R9");
    expect_quiet(5, "R9");
    check(timeout_flag, "R9", "flag held", timeout_flag, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(!timeout_flag, "R9", "flag cleared", timeout_flag, 0);
    expect_quiet(25, "R9");
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(timeout_flag && rst_req, "R9", "set wins over clear", timeout_flag, 1);
  endtask

  initial begin
    t_basic();
    t_ratios();
    t_cfg_frozen();
    t_window();
    t_coincide();
    t_events();
    t_enable();
    t_flag();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule